// File: doc/BRIEF.md
# Staggered-Symmetric Two-Stage Fabric Configuration Sequencer

This block produces the connection patterns for both crossbars of an N-port load-balanced two-stage switch. A slot counter steps through N slots and then repeats. In every slot, each input of the first crossbar is tied to one middle-stage port, and each middle-stage port of the second crossbar is tied to one output. Over one period, every pairing occurs exactly once.

The second crossbar's pattern is fixed by one rule. If middle port j serves output k in slot t, then input k reaches middle port j in slot t+1. Because of this, the occupancy report that travels with a packet to output k arrives just before the input on the same linecard talks to that middle port. The block also supplies the inverse of each map, so that ingress and egress logic can both index by their own port.

All maps are combinational functions of the registered slot number. No data passes through this block.

Top module: `staggered_cfg_seq`

## Requirements
- R1: While `rst_n` is low, `slot` is 0. The maps then show slot 0, which means `in_to_mid` entry i equals i.
- R2: `slot` increments by one on a rising clock edge only when `en` and `slot_tick` are both high at that edge. Otherwise it holds.
- R3: When the counter advances from slot N-1, the next value is 0.
- R4: Entry i of `in_to_mid` equals (i + slot) mod N. Every flat port carries entry e in bits [e*W +: W], with W = clog2(N).
- R5: Entry j of `mid_to_out` equals (j - slot - 1) mod N.
- R6: Suppose entry j of `mid_to_out` is k in one slot, and the counter then advances. In the next slot, entry k of `in_to_mid` is j.
- R7: Entry j of `mid_from_in` is (j - slot) mod N, the input feeding middle port j. Entry k of `out_from_mid` is (k + slot + 1) mod N, the middle port feeding output k. Each inverse map undoes its forward map in every slot.
- R8: In every slot, each of the four maps is a permutation of 0..N-1.
- R9: Across N consecutive slots, each input meets each middle port exactly once. Likewise, each middle port meets each output exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Lets the slot strobe advance the counter |
| slot_tick | input | 1 | Slot boundary strobe |
| slot | output | W | Current slot number |
| in_to_mid | output | N*W | Middle port that each input reaches in the first crossbar |
| mid_from_in | output | N*W | Input that feeds each middle port |
| mid_to_out | output | N*W | Output that each middle port reaches in the second crossbar |
| out_from_mid | output | N*W | Middle port that feeds each output |

## Verification
The strobe pair is sampled at a rising edge, and `slot` changes at that same edge. All four maps follow in that cycle, since no register sits between them and the counter. The bench drives `en` and `slot_tick` on a falling edge and advances its own slot model once for an accepted strobe. It then compares every output at the next falling edge, which is exactly one rising edge later. For the symmetry rule, the bench keeps the second-crossbar map from before the edge and compares it against the first-crossbar map after the edge.

// File: rtl/stg_pkg.sv
package stg_pkg;

  // (a + b) mod n for 0 <= a, b < n
  function automatic int mod_add(int a, int b, int n);
    int s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction

  // (a - b) mod n for 0 <= a, b < n
  function automatic int mod_sub(int a, int b, int n);
    return (a >= b) ? (a - b) : (a + n - b);
  endfunction

endpackage

// File: rtl/stg_slot_ctr.sv
module stg_slot_ctr #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         slot_tick,
  output logic [W-1:0] slot,
  output logic         slot_adv,
  output logic         slot_wrap
);

  localparam logic [W-1:0] LAST = W'(N - 1);

  assign slot_adv  = en & slot_tick;
  assign slot_wrap = slot_adv & (slot == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else if (slot_adv) begin
      if (slot == LAST) slot <= '0;
      else              slot <= slot + W'(1);
    end
  end

endmodule

// File: rtl/stg_first_map.sv
module stg_first_map #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [W-1:0]   slot,
  output logic [N*W-1:0] in_to_mid,
  output logic [N*W-1:0] mid_from_in
);
  import stg_pkg::*;

  for (genvar p = 0; p < N; p++) begin : g_port
    // input p -> middle (p + t)
    assign in_to_mid[p*W +: W]   = W'(mod_add(p, int'(slot), N));
    // middle p <- input (p - t)
    assign mid_from_in[p*W +: W] = W'(mod_sub(p, int'(slot), N));
  end

endmodule

// File: rtl/stg_second_map.sv
module stg_second_map #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [W-1:0]   slot,
  output logic [N*W-1:0] mid_to_out,
  output logic [N*W-1:0] out_from_mid
);
  import stg_pkg::*;

  // t+1 mod N, shared by all lanes
  logic [W-1:0] slot_nx;
  assign slot_nx = W'(mod_add(int'(slot), 1, N));

  for (genvar p = 0; p < N; p++) begin : g_port
    // middle p -> output (p - t - 1)
    assign mid_to_out[p*W +: W]   = W'(mod_sub(p, int'(slot_nx), N));
    // output p <- middle (p + t + 1)
    assign out_from_mid[p*W +: W] = W'(mod_add(p, int'(slot_nx), N));
  end

endmodule

// File: rtl/staggered_cfg_seq.sv
module staggered_cfg_seq #(
  parameter int N = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 en,
  input  logic                                 slot_tick,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] slot,
  output logic [N*((N > 1) ? $clog2(N) : 1)-1:0] in_to_mid,
  output logic [N*((N > 1) ? $clog2(N) : 1)-1:0] mid_from_in,
  output logic [N*((N > 1) ? $clog2(N) : 1)-1:0] mid_to_out,
  output logic [N*((N > 1) ? $clog2(N) : 1)-1:0] out_from_mid
);

  localparam int W = (N > 1) ? $clog2(N) : 1;

  // named events for the checker
  logic slot_adv;
  logic slot_wrap;

  stg_slot_ctr #(.N(N), .W(W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .slot_tick (slot_tick),
    .slot      (slot),
    .slot_adv  (slot_adv),
    .slot_wrap (slot_wrap)
  );

  stg_first_map #(.N(N), .W(W)) u_fab1 (
    .slot        (slot),
    .in_to_mid   (in_to_mid),
    .mid_from_in (mid_from_in)
  );

  stg_second_map #(.N(N), .W(W)) u_fab2 (
    .slot         (slot),
    .mid_to_out   (mid_to_out),
    .out_from_mid (out_from_mid)
  );

endmodule

// File: rtl/staggered_cfg_seq_chk.sv
module staggered_cfg_seq_chk #(
  parameter int N = 8,
  parameter int W = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           slot_tick,
  input logic           slot_wrap,
  input logic [W-1:0]   slot,
  input logic [N*W-1:0] in_to_mid,
  input logic [N*W-1:0] mid_from_in,
  input logic [N*W-1:0] mid_to_out,
  input logic [N*W-1:0] out_from_mid
);

  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] im_a [N];
  logic [W-1:0] mi_a [N];
  logic [W-1:0] mo_a [N];
  logic [W-1:0] om_a [N];

  for (genvar p = 0; p < N; p++) begin : g_unpack
    assign im_a[p] = in_to_mid[p*W +: W];
    assign mi_a[p] = mid_from_in[p*W +: W];
    assign mo_a[p] = mid_to_out[p*W +: W];
    assign om_a[p] = out_from_mid[p*W +: W];
  end

  logic [N-1:0] seen_im, seen_mi, seen_mo, seen_om;
  always_comb begin
    seen_im = '0;
    seen_mi = '0;
    seen_mo = '0;
    seen_om = '0;
    for (int p = 0; p < N; p++) begin
      seen_im[im_a[p]] = 1'b1;
      seen_mi[mi_a[p]] = 1'b1;
      seen_mo[mo_a[p]] = 1'b1;
      seen_om[om_a[p]] = 1'b1;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && slot_tick) |=> $stable(slot));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slot_tick && slot != LAST) |=> (slot == $past(slot) + W'(1)));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wrap |=> (slot == '0));

  // R3
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST);

  // R8
  perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&seen_im) && (&seen_mi) && (&seen_mo) && (&seen_om));

  for (genvar p = 0; p < N; p++) begin : g_lane
    // R6
    stagger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && slot_tick) |=> (im_a[$past(mo_a[p])] == W'(p)));

    // R7
    inv1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mi_a[im_a[p]] == W'(p));

    // R7
    inv2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      om_a[mo_a[p]] == W'(p));
  end

endmodule

bind staggered_cfg_seq staggered_cfg_seq_chk #(.N(N), .W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .slot_tick    (slot_tick),
  .slot_wrap    (slot_wrap),
  .slot         (slot),
  .in_to_mid    (in_to_mid),
  .mid_from_in  (mid_from_in),
  .mid_to_out   (mid_to_out),
  .out_from_mid (out_from_mid)
);

// File: tb/staggered_cfg_seq_tb.sv
`timescale 1ns/1ps
module staggered_cfg_seq_tb;

  localparam int N = 5;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic slot_tick = 1'b0;
  logic [W-1:0]   slot;
  logic [N*W-1:0] in_to_mid, mid_from_in, mid_to_out, out_from_mid;

  int n_chk = 0;
  int n_fail = 0;
  int ref_t = 0;
  bit done = 1'b0;
  int prev_mo [N];
  int meet1 [N][N];
  int meet2 [N][N];

  always #2.5 clk = ~clk;

  staggered_cfg_seq #(.N(N)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .slot_tick    (slot_tick),
    .slot         (slot),
    .in_to_mid    (in_to_mid),
    .mid_from_in  (mid_from_in),
    .mid_to_out   (mid_to_out),
    .out_from_mid (out_from_mid)
  );

  function automatic int fld(logic [N*W-1:0] v, int idx);
    return int'(v[idx*W +: W]);
  endfunction

  function automatic bit is_perm(logic [N*W-1:0] v);
    int cnt [N];
    for (int e = 0; e < N; e++) cnt[e] = 0;
    for (int e = 0; e < N; e++) begin
      if (fld(v, e) >= N) return 1'b0;
      cnt[fld(v, e)]++;
    end
    for (int e = 0; e < N; e++) if (cnt[e] != 1) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(bit adv, int prev_t);
    chk(int'(slot) == ref_t, (adv && prev_t == N-1) ? "R3 slot wrap" : "R2 slot",
        int'(slot), ref_t);
    for (int p = 0; p < N; p++) begin
      chk(fld(in_to_mid, p) == (p + ref_t) % N, "R4 in_to_mid",
          fld(in_to_mid, p), (p + ref_t) % N);
      chk(fld(mid_to_out, p) == (p - ref_t - 1 + 2*N) % N, "R5 mid_to_out",
          fld(mid_to_out, p), (p - ref_t - 1 + 2*N) % N);
      chk(fld(mid_from_in, p) == (p - ref_t + N) % N, "R7 mid_from_in",
          fld(mid_from_in, p), (p - ref_t + N) % N);
      chk(fld(out_from_mid, p) == (p + ref_t + 1) % N, "R7 out_from_mid",
          fld(out_from_mid, p), (p + ref_t + 1) % N);
      if (adv)
        chk(fld(in_to_mid, prev_mo[p]) == p, "R6 stagger",
            fld(in_to_mid, prev_mo[p]), p);
    end
    chk(is_perm(in_to_mid) && is_perm(mid_from_in) && is_perm(mid_to_out)
        && is_perm(out_from_mid), "R8 permutation", 0, 1);
  endtask

  task automatic step(bit e, bit k);
    int pt;
    bit adv;
    for (int p = 0; p < N; p++) prev_mo[p] = fld(mid_to_out, p);
    pt = ref_t;
    en = e;
    slot_tick = k;
    @(negedge clk);
    adv = e && k;
    if (adv) ref_t = (ref_t + 1) % N;
    check_all(adv, pt);
  endtask

  task automatic check_reset();
    chk(int'(slot) == 0, "R1 slot", int'(slot), 0);
    for (int p = 0; p < N; p++)
      chk(fld(in_to_mid, p) == p, "R1 in_to_mid", fld(in_to_mid, p), p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    ref_t = 0;
    @(negedge clk);
    check_all(1'b0, 0);

    // R9: one full period of advances, tally meetings
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) begin
        meet1[a][b] = 0;
        meet2[a][b] = 0;
      end
    for (int c = 0; c < N; c++) begin
      for (int p = 0; p < N; p++) begin
        meet1[p][fld(in_to_mid, p)]++;
        meet2[p][fld(mid_to_out, p)]++;
      end
      step(1'b1, 1'b1);
    end
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) begin
        chk(meet1[a][b] == 1, "R9 input/middle meet", meet1[a][b], 1);
        chk(meet2[a][b] == 1, "R9 middle/output meet", meet2[a][b], 1);
      end

    // more advances across a second wrap (R3)
    repeat (N + 2) step(1'b1, 1'b1);
    // strobe without enable: R2 hold
    repeat (4) step(1'b0, 1'b1);
    // enable without strobe: R2 hold
    repeat (4) step(1'b1, 1'b0);
    repeat (3) step(1'b0, 1'b0);
    // mixed pattern
    for (int c = 0; c < 60; c++)
      step((c % 3) != 0, ((c % 2) == 0) || ((c % 5) == 0));

    // reset in mid-run: R1
    rst_n = 1'b0;
    @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    ref_t = 0;
    repeat (N + 1) step(1'b1, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule